// File: doc/BRIEF.md
# Keyboard Wake-up Interrupt Controller

This block watches eight key lines and raises one interrupt request toward a processor when any of them becomes active. Software chooses, line by line, whether the line takes part and whether it counts as active when low or when high. The active lines are merged into one signal. A rising transition of that merged signal sets a pending latch, so a single key event produces one request however long the key is held.

A mode bit selects how the latch is cleared. In edge mode an acknowledge clears it at once. In level mode the request also holds while any enabled line stays active: it clears only after an acknowledge has been seen and every enabled line has returned to its inactive level. The acknowledge comes either from a strobe that the processor raises when it fetches the interrupt vector, or from software writing a one to a control bit. A mask bit blocks the outgoing request without hiding the pending latch from software.

Software reaches the block through a small byte-wide register port with a write strobe, a two-bit address and a registered read path. Key lines pass through a two-stage synchronizer first, so they may be fully asynchronous to the clock.

Top module: `kbd_wake_ctrl`

## Requirements
- R1: After reset all three registers read 0x00 (no line enabled, every polarity low-active, request unmasked, edge mode) and `irq` is 0.
- R2: Address 0 is control: bit 3 pending flag (read-only), bit 2 acknowledge (write 1, always reads 0), bit 1 mask, bit 0 mode (1 = level mode); bits 7:4 read 0. Address 1 is the line enable register, address 2 the polarity register, address 3 reads 0. `rd_data` shows the addressed register one clock after `addr` is applied.
- R3: For an enabled line, polarity bit 0 makes a high-to-low change active and polarity bit 1 a low-to-high change; the active change sets the pending flag within three clocks of the pin change.
- R4: Activity on lines whose enable bit is 0 never sets the pending flag.
- R5: In edge mode an acknowledge clears the pending flag even while the line stays active, and releasing the line afterwards does not set it again.
- R6: In level mode the pending flag stays set while any enabled line is active, even after an acknowledge; once an acknowledge has been seen it clears when all enabled lines are inactive. Without an acknowledge, releasing the line does not clear it (in either mode).
- R7: A one-cycle pulse on `vec_ack` acknowledges exactly as a software write of 1 to control bit 2.
- R8: A new active change after an acknowledge sets the flag again; when it coincides with an acknowledge in the same clock, setting wins.
- R9: `irq` is the pending flag with the mask applied, one clock later; with the mask bit 1 `irq` is 0 while the flag still reads 1.
- R10: A register write that makes an enabled line newly active (enable or polarity change) counts as an active change and sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| keys | input | 8 | Asynchronous key lines |
| vec_ack | input | 1 | Vector-fetch acknowledge strobe |
| irq | output | 1 | Interrupt request, high when pending and unmasked |

## Verification
On every clock the assertions check that a merged active change sets the latch, that in level mode a set latch cannot fall while an enabled line is active, that an edge-mode acknowledge without a coinciding change clears it, that a set mask keeps `irq` low, and that the unused control bits read zero. Only the bench scenarios show the polarity and enable sweep over all eight lines in both modes, the blocking of disabled lines, the equivalence of the two acknowledge paths, the coincident set-and-acknowledge case and the register-write triggered events, since these need a known sequence of pin levels and writes.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_EN   = 2'd1,
    REG_POL  = 2'd2,
    REG_NONE = 2'd3
  } kbd_reg_e;

  localparam int CTL_MODE = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_ACK  = 2;
  localparam int CTL_FLAG = 3;
endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
  import kbd_pkg::*;
#(
  parameter int N_KEYS = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pend,
  output logic [N_KEYS-1:0] en,
  output logic [N_KEYS-1:0] pol,
  output logic              mask,
  output logic              mode,
  output logic              sw_ack,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      pol  <= '0;
      mask <= 1'b0;
      mode <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        REG_CTRL: begin
          mask <= wr_data[CTL_MASK];
          mode <= wr_data[CTL_MODE];
        end
        REG_EN:  en  <= wr_data[N_KEYS-1:0];
        REG_POL: pol <= wr_data[N_KEYS-1:0];
        default: ;
      endcase
    end
  end

  assign sw_ack = wr_en && (addr == REG_CTRL) && wr_data[CTL_ACK];

  always_comb begin
    rd_next = '0;
    case (addr)
      REG_CTRL: begin
        rd_next[CTL_FLAG] = pend;
        rd_next[CTL_MASK] = mask;
        rd_next[CTL_MODE] = mode;
      end
      REG_EN:  rd_next[N_KEYS-1:0] = en;
      REG_POL: rd_next[N_KEYS-1:0] = pol;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R2
  ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == REG_CTRL) |=> (rd_data[DATA_W-1:4] == '0 && !rd_data[CTL_ACK]));
endmodule

// File: rtl/kbd_detect.sv
module kbd_detect #(
  parameter int N_KEYS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_KEYS-1:0] keys_s,
  input  logic [N_KEYS-1:0] en,
  input  logic [N_KEYS-1:0] pol,
  input  logic              mode,
  input  logic              mask,
  input  logic              ack,
  output logic              pend,
  output logic              irq
);
  logic [N_KEYS-1:0] act_vec;
  logic any_act, any_act_q, edge_c, arm_q, clear_ok, pend_d, arm_d;

  assign act_vec = en & ~(keys_s ^ pol);
  assign any_act = |act_vec;
  assign edge_c  = any_act && !any_act_q;
  assign clear_ok = mode ? ((ack || arm_q) && !any_act) : ack;

  always_comb begin
    if (edge_c)        pend_d = 1'b1;
    else if (clear_ok) pend_d = 1'b0;
    else               pend_d = pend;
    if (edge_c || !mode || !pend_d) arm_d = 1'b0;
    else if (ack)                   arm_d = 1'b1;
    else                            arm_d = arm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_act_q <= 1'b0;
      pend      <= 1'b0;
      arm_q     <= 1'b0;
      irq       <= 1'b0;
    end else begin
      any_act_q <= any_act;
      pend      <= pend_d;
      arm_q     <= arm_d;
      irq       <= pend && !mask;
    end
  end

  // R3
  edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
    edge_c |=> pend);
  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && any_act && pend) |=> pend);
  // R5
  edge_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && ack && !edge_c) |=> !pend);
  // R9
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mask |=> !irq);
endmodule

// File: rtl/kbd_wake_ctrl.sv
module kbd_wake_ctrl #(
  parameter int N_KEYS      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [N_KEYS-1:0] keys,
  input  logic              vec_ack,
  output logic              irq
);
  logic [N_KEYS-1:0] keys_s, en, pol;
  logic mask, mode, sw_ack, pend;

  kbd_sync #(.WIDTH(N_KEYS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(keys), .dout(keys_s)
  );

  kbd_regs #(.N_KEYS(N_KEYS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .pend(pend), .en(en), .pol(pol), .mask(mask), .mode(mode),
    .sw_ack(sw_ack), .rd_data(rd_data)
  );

  kbd_detect #(.N_KEYS(N_KEYS)) u_det (
    .clk(clk), .rst(rst), .keys_s(keys_s), .en(en), .pol(pol),
    .mode(mode), .mask(mask), .ack(sw_ack || vec_ack),
    .pend(pend), .irq(irq)
  );
endmodule

// File: tb/tb_kbd_wake_ctrl.sv
module tb_kbd_wake_ctrl;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, vec_ack = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'h00, keys = 8'h00, rd_data;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  kbd_wake_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .keys(keys), .vec_ack(vec_ack), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(posedge clk);
    @(negedge clk); d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flag(output logic f);
    logic [7:0] d;
    rd(2'd0, d);
    f = d[3];
  endtask

  task automatic pulse_vec;
    @(negedge clk); vec_ack = 1'b1;
    @(negedge clk); vec_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, idle, polv;
    logic f;
    wait_cyc(3);
    @(negedge clk); rst = 1'b0;

    // R1 reset values
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd1, d); check("R1 enable", d, 8'h00);
    rd(2'd2, d); check("R1 polarity", d, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2 register map with all lines inactive
    keys = ~8'h5A;
    wait_cyc(3);
    wr(2'd2, 8'h5A);
    wr(2'd1, 8'hA5);
    rd(2'd1, d); check("R2 enable", d, 8'hA5);
    rd(2'd2, d); check("R2 polarity", d, 8'h5A);
    rd(2'd3, d); check("R2 addr3", d, 8'h00);
    for (int v = 0; v < 256; v += 17) begin
      wr(2'd0, v[7:0]);
      rd(2'd0, d); check("R2 ctrl readback", d, {6'd0, v[1:0]});
    end
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h00);

    // R3 R4 R5 R6 R7 sweep: every line, both polarities, both modes
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 8; i++) begin
        for (int p = 0; p < 2; p++) begin
          polv = (p == 1) ? (8'h01 << i) : ~(8'h01 << i);
          idle = ~polv;
          keys = idle;
          wr(2'd1, 8'h00);
          wr(2'd2, polv);
          wait_cyc(3);
          wr(2'd1, 8'h01 << i);
          wr(2'd0, 8'h04 | m[7:0]);
          wait_cyc(3);
          flag(f); check("R3 idle", {7'd0, f}, 8'h00);
          keys = idle ^ ~(8'h01 << i);
          wait_cyc(4);
          flag(f); check("R4 disabled lines", {7'd0, f}, 8'h00);
          keys = idle ^ 8'hFF;
          wait_cyc(4);
          flag(f); check("R3 active change", {7'd0, f}, 8'h01);
          check("R9 irq", {7'd0, irq}, 8'h01);
          if (i % 2 == 0) wr(2'd0, 8'h04 | m[7:0]);
          else            pulse_vec();
          wait_cyc(3);
          flag(f);
          if (m == 0) check("R5 R7 ack while held", {7'd0, f}, 8'h00);
          else        check("R6 R7 ack while held", {7'd0, f}, 8'h01);
          keys = idle;
          wait_cyc(4);
          flag(f); check("R5 R6 after release", {7'd0, f}, 8'h00);
          keys = idle ^ (8'h01 << i);
          wait_cyc(4);
          keys = idle;
          wait_cyc(4);
          flag(f); check("R6 release without ack", {7'd0, f}, 8'h01);
          wr(2'd0, 8'h04 | m[7:0]);
          wait_cyc(3);
          flag(f); check("R6 ack when inactive", {7'd0, f}, 8'h00);
        end
      end
    end

    // R8 re-trigger after acknowledge (edge mode, line 2, rising)
    keys = 8'h00;
    wr(2'd2, 8'h04);
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h04);
    wait_cyc(3);
    keys = 8'h04; wait_cyc(4);
    wr(2'd0, 8'h04); wait_cyc(2);
    flag(f); check("R8 cleared", {7'd0, f}, 8'h00);
    keys = 8'h00; wait_cyc(4);
    keys = 8'h04; wait_cyc(4);
    flag(f); check("R8 new change sets", {7'd0, f}, 8'h01);
    keys = 8'h00; wait_cyc(4);
    wr(2'd0, 8'h04); wait_cyc(2);
    // R8 coincident change and acknowledge: ack write sampled at third edge
    @(negedge clk); keys = 8'h04;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wr_data = 8'h04;
    @(negedge clk); wr_en = 1'b0;
    wait_cyc(2);
    flag(f); check("R8 set wins", {7'd0, f}, 8'h01);

    // R9 mask gates irq only
    wr(2'd0, 8'h02); wait_cyc(2);
    check("R9 masked irq", {7'd0, irq}, 8'h00);
    flag(f); check("R9 flag under mask", {7'd0, f}, 8'h01);
    wr(2'd0, 8'h00); wait_cyc(2);
    check("R9 unmasked irq", {7'd0, irq}, 8'h01);

    // R10 register writes making a line active
    keys = 8'h08;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    wait_cyc(3);
    wr(2'd1, 8'h08);
    wr(2'd0, 8'h04); wait_cyc(3);
    flag(f); check("R10 idle", {7'd0, f}, 8'h00);
    wr(2'd2, 8'h08); wait_cyc(3);
    flag(f); check("R10 polarity write", {7'd0, f}, 8'h01);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h04); wait_cyc(3);
    flag(f); check("R10 cleared", {7'd0, f}, 8'h00);
    wr(2'd1, 8'h08); wait_cyc(3);
    flag(f); check("R10 enable write", {7'd0, f}, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule